// File: doc/BRIEF.md
# Parallel One-Time-Programmable Memory Emulator

This block is a clocked, synthesizable stand-in for a byte-wide parallel memory that can be programmed once and is then read like a ROM. A 2^ADDR_W by 8 array sits behind three active-low control pins: chip select `e_n`, output gate `g_n` and program strobe `p_n`. Two digital flags take the place of raised supply voltages. `vpp_high` marks a raised programming supply. `a9_high` marks the identification voltage on address line 9. From these five inputs a decoder picks one of seven modes: standby, program inhibit, output disable, read, identification, program or verify.

The external bus is split into `data_in`, `data_out` and a drive enable `data_oe`. While the block is not driving, `data_out` is held at zero. Programming is modelled as a timed strobe: `p_n` must stay low for a configurable number of clock edges before the word is committed. A write can only clear bits, so a word that has been programmed can be narrowed but never restored. An `erase_all` input returns the whole array to the blank state for simulation. Reset does not touch the stored words.

The full-size part uses ADDR_W = 17, which gives 131,072 words. The default is smaller so that the storage stays light during elaboration.

Top module: `eprom_emu`

## Requirements
- R1: The array holds 2^ADDR_W words of 8 bits. Holding `erase_all` high at a rising edge sets every word to 0xFF, and this takes precedence over any write in that cycle.
- R2: With `e_n`=0, `g_n`=0, `vpp_high`=0 and `a9_high`=0 (read), `data_oe` is 1 and `data_out` shows the word at `addr` combinationally. In this configuration `p_n` has no effect and never writes.
- R3: With `e_n`=1 and `vpp_high`=0 (standby), `data_oe` is 0 and `data_out` is 0, whatever the value of `g_n`.
- R4: With `e_n`=0 and `g_n`=1 (output disable), `data_oe` is 0.
- R5: A program pulse has three parts. First, `vpp_high`=1 and `e_n`=0 are held. Then `p_n` is sampled low on at least PGM_MIN_CYC consecutive rising edges. Finally `p_n` is sampled high at the next edge. At that final edge the word at `addr` is replaced by the old word AND `data_in`, using the values of `addr` and `data_in` at that edge.
- R6: Programming only clears bits. A second pulse to the same word yields the AND of both data values.
- R7: With `vpp_high`=1, `e_n`=0, `g_n`=0 and `p_n`=1 (verify), `data_oe` is 1 and `data_out` shows the stored word. `a9_high` is ignored in this mode.
- R8: With `vpp_high`=1 and `e_n`=1 (program inhibit), `data_oe` is 0. A `p_n` pulse of any length leaves the array unchanged.
- R9: With `a9_high`=1 in the read configuration, `data_out` gives the identification codes: 0x20 when `addr[0]`=0 and 0x05 when `addr[0]`=1.
- R10: A pulse sampled low on at least 1 but fewer than PGM_MIN_CYC edges writes nothing and sets `short_pulse`. Once set, `short_pulse` stays set until reset.
- R11: Reset clears `short_pulse` and the pulse timer and leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| data_in | input | 8 | Data to program |
| data_out | output | 8 | Read data; zero when not driving |
| data_oe | output | 1 | High while the data bus is driven |
| e_n | input | 1 | Chip select, active low |
| g_n | input | 1 | Output gate, active low |
| p_n | input | 1 | Program strobe, active low |
| vpp_high | input | 1 | Programming supply raised |
| a9_high | input | 1 | Identification voltage present on address line 9 |
| erase_all | input | 1 | Return every word to 0xFF |
| short_pulse | output | 1 | Sticky flag: a program pulse ended too early |

## Verification
The bench targets the pulse-length boundary. It checks that a pulse of exactly PGM_MIN_CYC edges commits and that one edge fewer does not. A timer that is off by one would either drop valid writes or accept short ones. Repeated programming of the same word checks the AND rule: a design that overwrote the word would bring back bits that were already cleared. Long strobes are also applied while chip select is high and while the supply flag is low. A decoder that ignored `e_n` or `vpp_high` would corrupt the array there, and the corruption shows up on a later read. The bench also checks the identification codes against `addr[0]`, checks that verify mode ignores `a9_high`, and checks that the array survives reset while the sticky flag clears.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  localparam int WORD_W = 8;

  localparam logic [WORD_W-1:0] BLANK_WORD = 8'hFF;
  localparam logic [WORD_W-1:0] ID_MAKER   = 8'h20;
  localparam logic [WORD_W-1:0] ID_PART    = 8'h05;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_OUTDIS,
    MD_READ,
    MD_IDENT,
    MD_PROGRAM,
    MD_VERIFY
  } mode_e;

  // Priority: chip select, then supply flag, then strobe/gate, then id voltage.
  function automatic mode_e decode_mode(input logic e_n, input logic g_n,
                                        input logic p_n, input logic vpp_high,
                                        input logic a9_high);
    if (e_n) return vpp_high ? MD_INHIBIT : MD_STANDBY;
    if (vpp_high) begin
      if (!p_n) return MD_PROGRAM;
      if (!g_n) return MD_VERIFY;
      return MD_OUTDIS;
    end
    if (g_n) return MD_OUTDIS;
    return a9_high ? MD_IDENT : MD_READ;
  endfunction

  function automatic logic mode_drives(input mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
  endfunction

  function automatic logic [WORD_W-1:0] id_code(input logic sel);
    return sel ? ID_PART : ID_MAKER;
  endfunction

  // One-way programming: a zero can be added, a one never restored.
  function automatic logic [WORD_W-1:0] merge_program(input logic [WORD_W-1:0] old_w,
                                                      input logic [WORD_W-1:0] new_w);
    return old_w & new_w;
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  e_n,
  input  logic  g_n,
  input  logic  p_n,
  input  logic  vpp_high,
  input  logic  a9_high,
  output mode_e mode,
  output logic  drive_en,
  output logic  ident_sel,
  output logic  prog_window
);

  always_comb begin
    mode        = decode_mode(e_n, g_n, p_n, vpp_high, a9_high);
    drive_en    = mode_drives(mode);
    ident_sel   = (mode == MD_IDENT);
    prog_window = !e_n && vpp_high;
  end

endmodule

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
  parameter int MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic window,
  input  logic p_n,
  output logic commit,
  output logic short_evt,
  output logic short_pulse
);

  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(MIN_CYC);

  logic [CW-1:0] cnt;
  logic          in_pulse;
  logic          ending;

  always_comb begin
    in_pulse  = window && !p_n;
    ending    = (cnt != '0) && !in_pulse && !rst;
    commit    = ending && window && (cnt == CNT_FULL);
    short_evt = ending && (cnt != CNT_FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (in_pulse) begin
      if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            short_pulse <= 1'b0;
    else if (short_evt) short_pulse <= 1'b1;
  end

endmodule

// File: rtl/eprom_array.sv
module eprom_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              erase_all,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] next_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_comb begin
    rd_data   = mem[addr];
    next_word = merge_program(rd_data, wr_data);
  end

  always_ff @(posedge clk) begin
    if (erase_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_WORD;
    end else if (wr_en) begin
      mem[addr] <= next_word;
    end
  end

endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
  import eprom_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PGM_MIN_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe,
  input  logic              e_n,
  input  logic              g_n,
  input  logic              p_n,
  input  logic              vpp_high,
  input  logic              a9_high,
  input  logic              erase_all,
  output logic              short_pulse
);

  mode_e             mode;
  logic              drive_en;
  logic              ident_sel;
  logic              prog_window;
  logic              wr_commit;
  logic              short_evt;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] next_word;

  eprom_mode_dec u_dec (
    .e_n        (e_n),
    .g_n        (g_n),
    .p_n        (p_n),
    .vpp_high   (vpp_high),
    .a9_high    (a9_high),
    .mode       (mode),
    .drive_en   (drive_en),
    .ident_sel  (ident_sel),
    .prog_window(prog_window)
  );

  eprom_pulse_timer #(.MIN_CYC(PGM_MIN_CYC)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .window     (prog_window),
    .p_n        (p_n),
    .commit     (wr_commit),
    .short_evt  (short_evt),
    .short_pulse(short_pulse)
  );

  eprom_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk      (clk),
    .erase_all(erase_all),
    .wr_en    (wr_commit),
    .addr     (addr),
    .wr_data  (data_in),
    .rd_data  (rd_word),
    .next_word(next_word)
  );

  always_comb begin
    data_oe  = drive_en;
    data_out = '0;
    if (drive_en) data_out = ident_sel ? id_code(addr[0]) : rd_word;
  end

endmodule

// File: rtl/eprom_emu_chk.sv
module eprom_emu_chk
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        data_out,
  input logic              data_oe,
  input logic              e_n,
  input logic              g_n,
  input logic              p_n,
  input logic              vpp_high,
  input logic              a9_high,
  input logic              erase_all,
  input logic              short_pulse,
  input logic              wr_commit,
  input logic              short_evt,
  input logic [7:0]        next_word
);

  // R3
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (e_n && !vpp_high) |-> (!data_oe && data_out == 8'h00));

  // R4
  outdis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!e_n && g_n) |-> !data_oe);

  // R9
  ident_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!e_n && !g_n && !vpp_high && a9_high) |->
      (data_oe && data_out == (addr[0] ? 8'h05 : 8'h20)));

  // R8
  inhibit_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    e_n |-> !wr_commit);

  // R5
  commit_cond_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (vpp_high && !e_n && p_n));

  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !erase_all) |=> (data_out & ~$past(next_word)) == 8'h00 || !data_oe);

  // R10
  short_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    short_pulse |=> short_pulse);

  // R10
  short_sets_chk: assert property (@(posedge clk) disable iff (rst)
    short_evt |=> short_pulse);

  // R2
  read_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (data_oe && $past(data_oe) && $stable(addr) && $stable(a9_high) &&
     $stable(vpp_high) && !$past(wr_commit) && !$past(erase_all) && !$past(rst))
      |-> $stable(data_out));

  // R2
  no_write_low_supply_chk: assert property (@(posedge clk) disable iff (rst)
    !vpp_high |-> !wr_commit);

  logic unused_ok;
  assign unused_ok = ^{g_n, p_n};

endmodule

bind eprom_emu eprom_emu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .data_out   (data_out),
  .data_oe    (data_oe),
  .e_n        (e_n),
  .g_n        (g_n),
  .p_n        (p_n),
  .vpp_high   (vpp_high),
  .a9_high    (a9_high),
  .erase_all  (erase_all),
  .short_pulse(short_pulse),
  .wr_commit  (wr_commit),
  .short_evt  (short_evt),
  .next_word  (next_word)
);

// File: tb/sim_eprom_emu.sv
module sim_eprom_emu;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 11;
  localparam int MINC = 8;
  localparam int NW   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic [7:0]    data_in;
  logic [7:0]    data_out;
  logic          data_oe;
  logic          e_n, g_n, p_n, vpp_high, a9_high, erase_all;
  logic          short_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] model [NW];
  bit         exp_short;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_emu #(.ADDR_W(AW), .PGM_MIN_CYC(MINC)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .e_n(e_n), .g_n(g_n),
    .p_n(p_n), .vpp_high(vpp_high), .a9_high(a9_high),
    .erase_all(erase_all), .short_pulse(short_pulse)
  );

  function automatic logic [7:0] exp_id(input logic a0);
    return a0 ? 8'h05 : 8'h20;
  endfunction

  function automatic logic [7:0] exp_after(input logic [7:0] old_w, input logic [7:0] d);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = old_w[b] ? d[b] : 1'b0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pins(input logic en, input logic gn, input logic pn,
                      input logic vp, input logic a9);
    e_n = en; g_n = gn; p_n = pn; vpp_high = vp; a9_high = a9;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    addr = a; pins(0, 0, 1, 0, 0);
    #1;
    chk(req, {7'd0, data_oe, data_out}, {7'd0, 1'b1, model[a]});
  endtask

  task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d, input int len);
    @(negedge clk);
    addr = a; data_in = d; pins(0, 1, 0, 1, 0);
    repeat (len) @(negedge clk);
    p_n = 1'b1;
    @(negedge clk);
    if (len >= MINC) model[a] = exp_after(model[a], d);
    else if (len > 0) exp_short = 1'b1;
    pins(0, 1, 1, 0, 0);
  endtask

  task automatic erase();
    @(negedge clk);
    erase_all = 1'b1;
    @(negedge clk);
    erase_all = 1'b0;
    for (int i = 0; i < NW; i++) model[i] = 8'hFF;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; addr = '0; data_in = '0; erase_all = 0; exp_short = 0;
    pins(1, 1, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R11 reset state of the flag, R3 standby quiet
    chk("R11 flag after reset", {15'd0, short_pulse}, 16'd0);
    chk("R3 standby", {7'd0, data_oe, data_out}, 16'd0);
    g_n = 0; #1;
    chk("R3 standby g_n low", {7'd0, data_oe, data_out}, 16'd0);

    erase();
    // R1 blank after erase
    do_read(11'd0, "R1 blank word 0");
    do_read(11'(NW - 1), "R1 blank last word");

    // R4 output disable
    @(negedge clk); addr = 11'd3; pins(0, 1, 1, 0, 0); #1;
    chk("R4 output disable", {15'd0, data_oe}, 16'd0);

    // R5 boundary: exactly MINC edges commits
    pulse(11'd10, 8'hA5, MINC);
    do_read(11'd10, "R5 exact min pulse");
    // R6 second pulse ANDs
    pulse(11'd10, 8'h5F, MINC + 3);
    do_read(11'd10, "R6 and of two pulses");
    chk("R6 expected value", {8'd0, model[10]}, 16'h0005);

    // R10 one edge short
    pulse(11'd11, 8'h00, MINC - 1);
    do_read(11'd11, "R10 short pulse no write");
    chk("R10 flag set", {15'd0, short_pulse}, 16'd1);
    pulse(11'd12, 8'h3C, MINC);
    chk("R10 flag sticky", {15'd0, short_pulse}, 16'd1);
    do_read(11'd12, "R5 write after short");

    // R8 inhibit: long strobe with chip select high
    @(negedge clk); addr = 11'd20; data_in = 8'h00; pins(1, 0, 0, 1, 0);
    #1; chk("R8 inhibit quiet", {15'd0, data_oe}, 16'd0);
    repeat (MINC + 2) @(negedge clk);
    p_n = 1; @(negedge clk);
    do_read(11'd20, "R8 inhibit no write");

    // R2 strobe without supply flag
    @(negedge clk); addr = 11'd21; data_in = 8'h00; pins(0, 0, 0, 0, 0);
    repeat (MINC + 2) @(negedge clk);
    p_n = 1; @(negedge clk);
    do_read(11'd21, "R2 strobe ignored without supply");

    // R7 verify ignores a9
    @(negedge clk); addr = 11'd10; pins(0, 0, 1, 1, 1); #1;
    chk("R7 verify", {7'd0, data_oe, data_out}, {8'h01, model[10]});

    // R9 identification
    @(negedge clk); addr = 11'd0; pins(0, 0, 1, 0, 1); #1;
    chk("R9 maker code", {7'd0, data_oe, data_out}, {8'h01, exp_id(1'b0)});
    addr = 11'd513; #1;
    chk("R9 part code", {7'd0, data_oe, data_out}, {8'h01, exp_id(1'b1)});

    // Random programming mixed with short pulses
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] ra;
      logic [7:0]    rd;
      int            rl;
      ra = AW'($urandom_range(0, 63));
      rd = 8'($urandom);
      rl = $urandom_range(1, MINC + 3);
      pulse(ra, rd, rl);
      do_read(ra, rl >= MINC ? "R5 random commit" : "R10 random short");
    end
    for (int n = 0; n < 30; n++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom_range(0, 63));
      do_read(ra, "R6 random readback");
    end
    chk("R10 flag after random", {15'd0, short_pulse}, {15'd0, exp_short});

    // R11 reset keeps array, clears flag
    @(negedge clk); rst = 1; pins(1, 1, 1, 0, 0);
    repeat (2) @(negedge clk); rst = 0; exp_short = 0; #1;
    chk("R11 flag cleared", {15'd0, short_pulse}, 16'd0);
    do_read(11'd10, "R11 array kept after reset");
    do_read(11'd12, "R11 array kept after reset 2");

    // R1 erase again
    erase();
    do_read(11'd10, "R1 erased again");
    do_read(AW'($urandom_range(0, NW - 1)), "R1 erased random");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule